// File: doc/BRIEF.md
# Dual-Mode Processor Register Bridge

This block is a slave port that gives a local microprocessor asynchronous read and write access to a small file of 8-bit registers. A three-bit strap input picks the bus signalling. In Intel style the processor drives separate active-low read and write strobes. In Motorola style it drives one active-low data strobe and a read/write select. A single handshake line serves both styles. In Intel style it is a READY line, where low stretches the cycle. In Motorola style it is an active-low DTACK, where low ends the cycle.

The strobes pass through a two-flop synchronizer on the internal clock. The handshake holds off for `WAIT_CYC` internal cycles after the synchronized strobe appears, then signals completion until the strobe goes away. A write takes effect after its strobe is removed. It uses the address and data captured while the synchronized strobe was high. The block also collects interrupt events into a pending register that software clears by writing ones. The open-drain active-low interrupt line is modelled as a pull-down enable. The bidirectional data bus is modelled as separate in, out and enable signals.

Register map (4-bit address): 0 to 3 are read/write scratch registers. 4 is interrupt pending (write 1 to clear). 5 is interrupt enable. Every other address reads 0 and ignores writes.

Top module: `mpbr_top`

## Requirements
- R1: Mode code 3'b001 selects Motorola style. Code 3'b000 and every other code select Intel style.
- R2: In Intel style, while rd_ds_ni is low, data_oe_o is 1 and data_o holds the register at addr_i. data_oe_o drops at once, with no clock edge, when rd_ds_ni rises.
- R3: In Motorola style, data_oe_o is 1 and data_o holds the addressed register only while rd_ds_ni is low with rw_i = 1. With rw_i = 0 the bus is not driven.
- R4: An asynchronous low on rst_ni clears every register to 0. While rst_ni is low, data_oe_o, hs_oe_o and irq_oe_o are 0.
- R5: In Intel style hs_o is high while idle. Sampled once per cycle after a strobe asserts, it is low for exactly WAIT_CYC samples, then high while the strobe stays asserted.
- R6: In Motorola style hs_o is high while idle. After a strobe asserts it stays high for WAIT_CYC+2 cycle samples, then stays low until the strobe is removed. It returns high within 4 cycles of removal.
- R7: A write lands at its address once its strobe is removed. The write strobe is wr_ni in Intel style, and rd_ds_ni with rw_i = 0 in Motorola style. Writes to addresses 6 to 15 have no effect, and those addresses read 0.
- R8: A one on bit i of irq_set_i sets pending bit i. Writing to address 4 clears the pending bits where the written data is 1. A set in the same cycle wins over the clear.
- R9: irq_oe_o is 1 exactly when some pending bit has its enable bit (address 5) set. It falls only as a result of a register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_sel_i | input | 3 | Strapped bus style code |
| addr_i | input | 4 | Register address |
| data_i | input | 8 | Data bus, inbound |
| data_o | output | 8 | Data bus, outbound |
| data_oe_o | output | 1 | Data bus output enable |
| rd_ds_ni | input | 1 | Read strobe (Intel) or data strobe (Motorola), active low |
| wr_ni | input | 1 | Write strobe, Intel style, active low |
| rw_i | input | 1 | Motorola read/write select, 1 = read |
| hs_o | output | 1 | Handshake level: READY or DTACK_n |
| hs_oe_o | output | 1 | Handshake driver enable |
| irq_set_i | input | 8 | Interrupt event pulses, one per pending bit |
| irq_oe_o | output | 1 | Interrupt pull-down enable (line active low) |

## Verification
The assertions assume a well-formed processor cycle. Only one strobe kind is active at a time. rw_i, addr_i and data_i stay stable from strobe assertion until a few cycles after strobe removal. The mode strap changes only while the bus is idle. The bench drives every input on the falling clock edge. It holds address, data and select for four cycles after each strobe is released. It waits for the handshake to return to idle before the next access, and it changes mode only between accesses.

// File: rtl/mpbr_pkg.sv
`timescale 1ns/1ps
package mpbr_pkg;
  localparam logic [2:0] MODE_MOTO = 3'b001;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_WAIT = 2'd1,
    HS_DONE = 2'd2
  } hs_state_e;
endpackage

// File: rtl/mpbr_sync.sv
`timescale 1ns/1ps
module mpbr_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end
    assign q_o[g] = sync_q;
  end
endmodule

// File: rtl/mpbr_bus_ctrl.sv
`timescale 1ns/1ps
module mpbr_bus_ctrl
  import mpbr_pkg::*;
#(
  parameter int AW       = 4,
  parameter int DW       = 8,
  parameter int WAIT_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          is_moto_i,
  input  logic          rd_raw_i,
  input  logic          wr_raw_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o,
  output logic          hs_o,
  output logic          hs_oe_o
);
  localparam int CW = $clog2(WAIT_CYC + 1);

  logic [1:0]    s_req;
  logic          s_rd, s_wr, s_act, s_wr_q, drv_q;
  logic [AW-1:0] cap_addr_q;
  logic [DW-1:0] cap_data_q;
  logic [CW-1:0] cnt_q;
  hs_state_e     state_q;

  mpbr_sync #(.W(2)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({wr_raw_i, rd_raw_i}),
    .q_o   (s_req)
  );

  assign s_rd  = s_req[0];
  assign s_wr  = s_req[1];
  assign s_act = s_rd | s_wr;

  // capture address/data while the synchronized write strobe is active
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_wr_q     <= 1'b0;
      cap_addr_q <= '0;
      cap_data_q <= '0;
      drv_q      <= 1'b0;
    end else begin
      s_wr_q <= s_wr;
      drv_q  <= 1'b1;
      if (s_wr) begin
        cap_addr_q <= addr_i;
        cap_data_q <= data_i;
      end
    end
  end

  assign we_o    = s_wr_q & ~s_wr;
  assign waddr_o = cap_addr_q;
  assign wdata_o = cap_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        HS_IDLE: if (s_act) begin
          state_q <= HS_WAIT;
          cnt_q   <= CW'(1);
        end
        HS_WAIT: begin
          if (cnt_q == CW'(WAIT_CYC)) state_q <= HS_DONE;
          else                        cnt_q   <= cnt_q + CW'(1);
        end
        HS_DONE: if (!s_act) state_q <= HS_IDLE;
        default: state_q <= HS_IDLE;
      endcase
    end
  end

  // Intel: READY low while waiting; Motorola: DTACK_n low when done
  assign hs_o    = is_moto_i ? (state_q != HS_DONE) : (state_q != HS_WAIT);
  assign hs_oe_o = drv_q;

  a_r5_done_after_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HS_DONE) |-> ($past(state_q) != HS_IDLE));

  a_r6_no_ack_unstrobed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HS_IDLE && !s_act) |=> (state_q == HS_IDLE));
endmodule

// File: rtl/mpbr_regfile.sv
`timescale 1ns/1ps
module mpbr_regfile #(
  parameter int AW      = 4,
  parameter int DW      = 8,
  parameter int NUM_SCR = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] irq_set_i,
  output logic          irq_oe_o
);
  localparam logic [AW-1:0] STAT_ADDR = AW'(NUM_SCR);
  localparam logic [AW-1:0] EN_ADDR   = AW'(NUM_SCR + 1);

  logic [DW-1:0] scr_q [NUM_SCR];
  logic [DW-1:0] pend_q, en_q, clr_mask;

  for (genvar g = 0; g < NUM_SCR; g++) begin : g_scr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           scr_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g))    scr_q[g] <= wdata_i;
    end

    a_r7_scr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(we_i && waddr_i == AW'(g)) |=> $stable(scr_q[g]));
  end

  assign clr_mask = (we_i && waddr_i == STAT_ADDR) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_mask) | irq_set_i;
      if (we_i && waddr_i == EN_ADDR) en_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_SCR; i++)
      if (raddr_i == AW'(i)) rdata_o = scr_q[i];
    if (raddr_i == STAT_ADDR) rdata_o = pend_q;
    if (raddr_i == EN_ADDR)   rdata_o = en_q;
  end

  assign irq_oe_o = |(pend_q & en_q);

  a_r8_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i == STAT_ADDR && irq_set_i == '0) |=> ((pend_q & $past(wdata_i)) == '0));

  a_r9_release_by_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_oe_o) |-> $past(we_i));
endmodule

// File: rtl/mpbr_top.sv
`timescale 1ns/1ps
module mpbr_top
  import mpbr_pkg::*;
#(
  parameter int AW       = 4,
  parameter int DW       = 8,
  parameter int NUM_SCR  = 4,
  parameter int WAIT_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    mode_sel_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  input  logic          rd_ds_ni,
  input  logic          wr_ni,
  input  logic          rw_i,
  output logic          hs_o,
  output logic          hs_oe_o,
  input  logic [DW-1:0] irq_set_i,
  output logic          irq_oe_o
);
  logic          is_moto, rd_raw, wr_raw, we;
  logic [AW-1:0] waddr;
  logic [DW-1:0] wdata;

  assign is_moto = (mode_sel_i == MODE_MOTO);
  assign rd_raw  = is_moto ? (!rd_ds_ni &&  rw_i) : !rd_ds_ni;
  assign wr_raw  = is_moto ? (!rd_ds_ni && !rw_i) : !wr_ni;

  assign data_oe_o = rst_ni & rd_raw;

  mpbr_bus_ctrl #(.AW(AW), .DW(DW), .WAIT_CYC(WAIT_CYC)) i_bus_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .is_moto_i(is_moto),
    .rd_raw_i (rd_raw),
    .wr_raw_i (wr_raw),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .we_o     (we),
    .waddr_o  (waddr),
    .wdata_o  (wdata),
    .hs_o     (hs_o),
    .hs_oe_o  (hs_oe_o)
  );

  mpbr_regfile #(.AW(AW), .DW(DW), .NUM_SCR(NUM_SCR)) i_regfile (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we),
    .waddr_i  (waddr),
    .wdata_i  (wdata),
    .raddr_i  (addr_i),
    .rdata_o  (data_o),
    .irq_set_i(irq_set_i),
    .irq_oe_o (irq_oe_o)
  );

  a_r4_released_in_reset: assert property (@(posedge clk_i)
    !rst_ni |-> (!data_oe_o && !hs_oe_o && !irq_oe_o));
endmodule

// File: tb/test_mpbr_top.sv
`timescale 1ns/1ps
module test_mpbr_top;
  localparam int WAIT_CYC = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'b000;
  logic [3:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       doe, rd_ds_n = 1'b1, wr_n = 1'b1, rw = 1'b1;
  logic       hs, hs_oe, irq_oe;
  logic [7:0] irq_set = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  mpbr_top #(.WAIT_CYC(WAIT_CYC)) i_mpbr_top (
    .clk_i(clk), .rst_ni(rst_n), .mode_sel_i(mode), .addr_i(addr),
    .data_i(din), .data_o(dout), .data_oe_o(doe), .rd_ds_ni(rd_ds_n),
    .wr_ni(wr_n), .rw_i(rw), .hs_o(hs), .hs_oe_o(hs_oe),
    .irq_set_i(irq_set), .irq_oe_o(irq_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
    #1;
  endtask

  function automatic bit moto();
    return mode == 3'b001;
  endfunction

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d;
    if (moto()) begin rw = 1'b0; rd_ds_n = 1'b0; end
    else wr_n = 1'b0;
    cyc(8);
    chk(doe == 1'b0, "R3 no drive on write", doe, 0);
    @(negedge clk);
    rd_ds_n = 1'b1; wr_n = 1'b1;
    cyc(4);
    rw = 1'b1;
  endtask

  task automatic bus_read(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = a; rw = 1'b1; rd_ds_n = 1'b0;
    cyc(1);
    chk(doe == 1'b1, req, doe, 1);
    chk(dout == exp, req, dout, exp);
    cyc(7);
    @(negedge clk);
    rd_ds_n = 1'b1;
    #1;
    chk(doe == 1'b0, "R2 bus released", doe, 0);
    cyc(4);
  endtask

  task automatic t_reset();
    #1;
    chk(doe == 0 && hs_oe == 0 && irq_oe == 0, "R4 outputs in reset", {doe, hs_oe, irq_oe}, 0);
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    chk(hs_oe == 1'b1, "R4 handshake driven after reset", hs_oe, 1);
    bus_read(4'd0, 8'h00, "R4 scratch default");
    bus_read(4'd5, 8'h00, "R4 enable default");
  endtask

  task automatic t_intel_rw();
    mode = 3'b000;
    bus_write(4'd0, 8'hA5);
    bus_write(4'd3, 8'h3C);
    bus_read(4'd0, 8'hA5, "R7 R2 intel read scr0");
    bus_read(4'd3, 8'h3C, "R7 R2 intel read scr3");
  endtask

  task automatic t_intel_ready();
    int lows = 0;
    mode = 3'b000;
    cyc(1);
    chk(hs == 1'b1, "R5 ready idle high", hs, 1);
    @(negedge clk);
    addr = 4'd0; rd_ds_n = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); #1;
      if (!hs) lows++;
    end
    chk(lows == WAIT_CYC, "R5 ready low cycles", lows, WAIT_CYC);
    chk(hs == 1'b1, "R5 ready high while strobed", hs, 1);
    @(negedge clk);
    rd_ds_n = 1'b1;
    cyc(4);
    chk(hs == 1'b1, "R5 ready idle after", hs, 1);
  endtask

  task automatic t_moto_rw();
    mode = 3'b001;
    bus_write(4'd1, 8'h5A);
    bus_read(4'd1, 8'h5A, "R3 R7 moto read scr1");
    bus_read(4'd0, 8'hA5, "R3 moto read scr0");
  endtask

  task automatic t_moto_dtack();
    int highs = 0;
    bit seen_low = 1'b0;
    mode = 3'b001;
    cyc(1);
    chk(hs == 1'b1, "R6 dtack idle high", hs, 1);
    @(negedge clk);
    addr = 4'd1; rw = 1'b1; rd_ds_n = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); #1;
      if (!hs) seen_low = 1'b1;
      else if (!seen_low) highs++;
    end
    chk(highs == WAIT_CYC + 2, "R6 dtack hold-off", highs, WAIT_CYC + 2);
    chk(hs == 1'b0, "R6 dtack low until release", hs, 0);
    @(negedge clk);
    rd_ds_n = 1'b1;
    cyc(4);
    chk(hs == 1'b1, "R6 dtack released", hs, 1);
  endtask

  task automatic t_mode_default();
    int lows = 0;
    mode = 3'b101;
    bus_write(4'd2, 8'hC3);
    bus_read(4'd2, 8'hC3, "R1 unsupported code acts as intel");
    @(negedge clk);
    rd_ds_n = 1'b0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); #1;
      if (!hs) lows++;
    end
    chk(lows == WAIT_CYC, "R1 ready semantics in default mode", lows, WAIT_CYC);
    @(negedge clk);
    rd_ds_n = 1'b1;
    cyc(4);
    mode = 3'b000;
  endtask

  task automatic t_unmapped();
    mode = 3'b000;
    bus_write(4'd9, 8'hFF);
    bus_read(4'd9, 8'h00, "R7 unmapped reads zero");
    bus_read(4'd0, 8'hA5, "R7 unmapped write no effect");
  endtask

  task automatic t_irq();
    mode = 3'b000;
    bus_write(4'd5, 8'h03);
    @(negedge clk);
    irq_set = 8'h04;
    @(negedge clk);
    irq_set = 8'h00;
    #1;
    chk(irq_oe == 1'b0, "R9 masked source no irq", irq_oe, 0);
    @(negedge clk);
    irq_set = 8'h01;
    @(negedge clk);
    irq_set = 8'h00;
    #1;
    chk(irq_oe == 1'b1, "R9 enabled source irq", irq_oe, 1);
    bus_read(4'd4, 8'h05, "R8 pending bits");
    bus_write(4'd4, 8'h01);
    chk(irq_oe == 1'b0, "R9 released after clear", irq_oe, 0);
    bus_read(4'd4, 8'h04, "R8 w1c leaves others");
  endtask

  task automatic t_async_reset();
    mode = 3'b000;
    @(negedge clk);
    addr = 4'd0; rd_ds_n = 1'b0;
    #1;
    chk(doe == 1'b1, "R2 drive before reset", doe, 1);
    #1;
    rst_n = 1'b0;
    #1;
    chk(doe == 0 && hs_oe == 0 && irq_oe == 0, "R4 async release", {doe, hs_oe, irq_oe}, 0);
    rd_ds_n = 1'b1;
    cyc(2);
    rst_n = 1'b1;
    cyc(2);
    bus_read(4'd0, 8'h00, "R4 scratch cleared");
    bus_read(4'd4, 8'h00, "R4 pending cleared");
  endtask

  initial begin
    t_reset();
    t_intel_rw();
    t_intel_ready();
    t_moto_rw();
    t_moto_dtack();
    t_mode_default();
    t_unmapped();
    t_irq();
    t_async_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule